// File: doc/BRIEF.md
# Dual-Target Level Interrupt Aggregator

This block gathers a set of active-high, level-sensitive interrupt request lines into a single 32-bit status word. Four independent enable masks steer that word to four outputs: a normal interrupt line for each of two processor cores, and a machine-check line for each of the same two cores. Each output is the OR of the status bits that its mask enables. No source is ever latched or acknowledged. A request goes away only when the device driving it drops its line, so software clears an interrupt at the device itself.

A small word-addressed register bus gives software a read-only view of the status word and read/write access to all four masks. It also provides a read-only helper register that reports the highest-numbered source that is both pending and enabled on core 0's interrupt line. Each input passes through a synchronizer before it reaches the status word, and every output is registered.

Only the lowest `LIVE_SRC` status positions are wired to inputs. The positions above them always read as zero.

Top module: `irq_aggregator`

## Requirements
- R1: Status bit i (i < LIVE_SRC, default 17) equals the level of `irq_src[i]` after a two-flop synchronizer. Status bits LIVE_SRC..31 always read 0, whatever their input pins do. Status is read at byte offset 0x00.
- R2: A bus write to offset 0x00 changes neither the status word nor any mask.
- R3: The masks are readable and writable at these byte offsets:
  - 0x10: interrupt enable for core 0
  - 0x14: interrupt enable for core 1
  - 0x18: machine-check enable for core 0
  - 0x1C: machine-check enable for core 1

  In every mask, bit value 1 enables the source at the same position and 0 blocks it. A write takes effect in one clock and reads back unchanged.
- R4: After reset all four masks read 0 and all four outputs are low.
- R5: Each output (`core_irq[n]`, `core_mchk[n]`) equals the OR of (status AND its mask) from the previous clock. An input change therefore appears at an enabled output on the third rising edge after it is sampled.
- R6: A single source that is enabled in several masks asserts every one of the matching outputs at the same time.
- R7: Nothing is held: when a source drops, its status bit and any output it alone was driving return to 0 with the same latency as R5.
- R8: Offset 0x20 is read-only. It returns the index (0..31) of the highest-numbered bit set in (status AND core-0 interrupt mask). When no such bit is set it returns 0x8000_0000.
- R9: A read of any offset other than 0x00, 0x10, 0x14, 0x18, 0x1C and 0x20 returns 0.
- R10: Reads are registered: `bus_rdata` shows the register at the address presented on the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | 32 | Level-sensitive interrupt request inputs, active high |
| bus_addr | input | ADDR_W (8) | Byte address of register access |
| bus_we | input | 1 | Write strobe, single cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| core_irq | output | 2 | Interrupt line per core |
| core_mchk | output | 2 | Machine-check line per core |

## Verification
The bench builds the block with its defaults: 17 live sources, a two-stage synchronizer and an 8-bit address. With these values the reserved status positions 17..31 can be driven high at the pins and are seen to read zero. The default synchronizer depth makes the three-edge input-to-output latency exact and countable. The 8-bit address also lets unmapped offsets both below and above the map be read back.

// File: rtl/irqa_pkg.sv
package irqa_pkg;
  localparam int unsigned REG_W     = 32;
  localparam int unsigned NCORE     = 2;
  localparam int unsigned OFS_STAT  = 'h00;
  localparam int unsigned OFS_IEN   = 'h10;
  localparam int unsigned OFS_MCK   = 'h18;
  localparam int unsigned OFS_HIGH  = 'h20;
  localparam int unsigned OFS_STEP  = 4;
  localparam logic [REG_W-1:0] NONE_CODE = 32'h8000_0000;

  // positions that are wired to real inputs
  function automatic logic [REG_W-1:0] live_mask(input int unsigned n);
    if (n >= REG_W) return '1;
    return (REG_W'(1) << n) - REG_W'(1);
  endfunction

  // highest set bit index, or NONE_CODE when the vector is empty
  function automatic logic [REG_W-1:0] top_index(input logic [REG_W-1:0] v);
    logic [REG_W-1:0] r;
    r = NONE_CODE;
    for (int i = 0; i < REG_W; i++) begin
      if (v[i]) r = REG_W'(i);
    end
    return r;
  endfunction

  function automatic logic any_hit(input logic [REG_W-1:0] st,
                                   input logic [REG_W-1:0] msk);
    return |(st & msk);
  endfunction
endpackage

// File: rtl/irqa_sync.sv
module irqa_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[s] <= '0;
        else if (s == 0) pipe[s] <= d;
        else pipe[s] <= pipe[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/irqa_regs.sv
module irqa_regs
  import irqa_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           addr,
  input  logic                        we,
  input  logic [REG_W-1:0]            wdata,
  input  logic [REG_W-1:0]            status,
  input  logic [REG_W-1:0]            high_code,
  output logic [REG_W-1:0]            rdata,
  output logic [NCORE-1:0][REG_W-1:0] ien_q,
  output logic [NCORE-1:0][REG_W-1:0] mck_q
);
  logic [NCORE-1:0] sel_ien, sel_mck;
  logic             sel_stat, sel_high;
  logic [REG_W-1:0] rd_next;

  assign sel_stat = (addr == ADDR_W'(OFS_STAT));
  assign sel_high = (addr == ADDR_W'(OFS_HIGH));

  generate
    for (genvar c = 0; c < NCORE; c++) begin : g_core
      assign sel_ien[c] = (addr == ADDR_W'(OFS_IEN + OFS_STEP*c));
      assign sel_mck[c] = (addr == ADDR_W'(OFS_MCK + OFS_STEP*c));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ien_q[c] <= '0;
          mck_q[c] <= '0;
        end else if (we) begin
          if (sel_ien[c]) ien_q[c] <= wdata;
          if (sel_mck[c]) mck_q[c] <= wdata;
        end
      end
    end
  endgenerate

  always_comb begin
    rd_next = '0;
    if (sel_stat) rd_next = status;
    if (sel_high) rd_next = high_code;
    for (int c = 0; c < NCORE; c++) begin
      if (sel_ien[c]) rd_next = ien_q[c];
      if (sel_mck[c]) rd_next = mck_q[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_next;
  end
endmodule

// File: rtl/irqa_route.sv
module irqa_route
  import irqa_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [REG_W-1:0]            status,
  input  logic [NCORE-1:0][REG_W-1:0] ien_q,
  input  logic [NCORE-1:0][REG_W-1:0] mck_q,
  output logic [NCORE-1:0]            hit_irq,
  output logic [NCORE-1:0]            hit_mck,
  output logic [NCORE-1:0]            irq_o,
  output logic [NCORE-1:0]            mck_o
);
  generate
    for (genvar c = 0; c < NCORE; c++) begin : g_line
      assign hit_irq[c] = any_hit(status, ien_q[c]);
      assign hit_mck[c] = any_hit(status, mck_q[c]);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          irq_o[c] <= 1'b0;
          mck_o[c] <= 1'b0;
        end else begin
          irq_o[c] <= hit_irq[c];
          mck_o[c] <= hit_mck[c];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irqa_pkg::*;
#(
  parameter int unsigned LIVE_SRC    = 17,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       irq_src,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [1:0]        core_irq,
  output logic [1:0]        core_mchk
);
  localparam logic [REG_W-1:0] LIVE = live_mask(LIVE_SRC);

  logic [REG_W-1:0]            sync_w;
  logic [REG_W-1:0]            status_w;
  logic [REG_W-1:0]            high_w;
  logic [NCORE-1:0][REG_W-1:0] ien_w;
  logic [NCORE-1:0][REG_W-1:0] mck_w;
  logic [NCORE-1:0]            hit_irq_w;
  logic [NCORE-1:0]            hit_mck_w;

  irqa_sync #(.WIDTH(REG_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(irq_src), .q(sync_w)
  );

  assign status_w = sync_w & LIVE;
  assign high_w   = top_index(status_w & ien_w[0]);

  irqa_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .status(status_w), .high_code(high_w), .rdata(bus_rdata),
    .ien_q(ien_w), .mck_q(mck_w)
  );

  irqa_route u_route (
    .clk(clk), .rst_n(rst_n), .status(status_w), .ien_q(ien_w), .mck_q(mck_w),
    .hit_irq(hit_irq_w), .hit_mck(hit_mck_w), .irq_o(core_irq), .mck_o(core_mchk)
  );
endmodule

// File: rtl/irqa_chk.sv
module irqa_chk
  import irqa_pkg::*;
#(
  parameter int unsigned LIVE_SRC = 17,
  parameter int unsigned ADDR_W   = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [REG_W-1:0]            status_w,
  input logic [NCORE-1:0][REG_W-1:0] ien_w,
  input logic [NCORE-1:0][REG_W-1:0] mck_w,
  input logic [ADDR_W-1:0]           bus_addr,
  input logic                        bus_we,
  input logic [31:0]                 bus_wdata,
  input logic [31:0]                 bus_rdata,
  input logic [1:0]                  core_irq,
  input logic [1:0]                  core_mchk
);
  // R1
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_w & ~live_mask(LIVE_SRC)) == '0);

  // R4
  masks_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ien_w == '0 && mck_w == '0));

  // R3
  ien0_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(OFS_IEN)) |=> ien_w[0] == $past(bus_wdata));

  // R5
  irq0_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> core_irq[0] == |($past(status_w) & $past(ien_w[0])));

  // R5
  irq1_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> core_irq[1] == |($past(status_w) & $past(ien_w[1])));

  // R5
  mchk0_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> core_mchk[0] == |($past(status_w) & $past(mck_w[0])));

  // R5
  mchk1_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> core_mchk[1] == |($past(status_w) & $past(mck_w[1])));

  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(4)) |=> bus_rdata == '0);

  // R8
  high_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(OFS_HIGH)) |=>
      (bus_rdata[31] ? (bus_rdata[30:0] == '0) : (bus_rdata < 32'd32)));
endmodule

bind irq_aggregator irqa_chk #(.LIVE_SRC(LIVE_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .status_w(status_w), .ien_w(ien_w), .mck_w(mck_w),
  .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .core_irq(core_irq), .core_mchk(core_mchk)
);

// File: tb/sim_irq_aggregator.sv
`timescale 1ns/1ps
module sim_irq_aggregator;
  localparam logic [31:0] LIVE = 32'h0001_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_src = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  core_irq, core_mchk;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] rng = 32'h1BAD_5EED;

  irq_aggregator u0 (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .core_irq(core_irq), .core_mchk(core_mchk)
  );

  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  function automatic logic [31:0] ref_high(input logic [31:0] v);
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) return 32'(i);
    end
    return 32'h8000_0000;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R4 irq after reset", {30'd0, core_irq}, 32'd0);
    check("R4 mchk after reset", {30'd0, core_mchk}, 32'd0);
    for (int k = 0; k < 4; k++) begin
      rd(8'h10 + 8'(4*k), v);
      check("R4 mask reset", v, 32'd0);
    end
  endtask

  task automatic t_mask_rw();
    logic [31:0] v;
    wr(8'h10, 32'hA5A5_0001); wr(8'h14, 32'h5A5A_0002);
    wr(8'h18, 32'h0F0F_0004); wr(8'h1C, 32'hF0F0_0008);
    rd(8'h10, v); check("R3 ien core0", v, 32'hA5A5_0001);
    rd(8'h14, v); check("R3 ien core1", v, 32'h5A5A_0002);
    rd(8'h18, v); check("R3 mchk core0", v, 32'h0F0F_0004);
    rd(8'h1C, v); check("R3 mchk core1", v, 32'hF0F0_0008);
    for (int k = 0; k < 4; k++) wr(8'h10 + 8'(4*k), 32'd0);
  endtask

  task automatic t_status();
    logic [31:0] v;
    irq_src = 32'hFFFF_FFFF; settle();
    rd(8'h00, v); check("R1 all high, reserved zero", v, LIVE);
    irq_src = 32'hDEAD_BEEF; settle();
    rd(8'h00, v); check("R1 pattern", v, 32'hDEAD_BEEF & LIVE);
    wr(8'h00, 32'h0000_0000);
    rd(8'h00, v); check("R2 status write ignored", v, 32'hDEAD_BEEF & LIVE);
    rd(8'h10, v); check("R2 mask untouched", v, 32'd0);
    rd(8'h1C, v); check("R2 mask untouched", v, 32'd0);
    irq_src = '0; settle();
  endtask

  task automatic t_latency();
    wr(8'h10, 32'h0000_0008); settle();
    @(negedge clk); irq_src[3] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R5 not yet after two edges", {31'd0, core_irq[0]}, 32'd0);
    @(negedge clk);
    check("R5 set on third edge", {31'd0, core_irq[0]}, 32'd1);
    check("R5 other lines quiet", {29'd0, core_irq[1], core_mchk}, 32'd0);
    irq_src[3] = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R7 still high two edges after drop", {31'd0, core_irq[0]}, 32'd1);
    @(negedge clk);
    check("R7 cleared on third edge", {31'd0, core_irq[0]}, 32'd0);
    wr(8'h10, 32'd0);
  endtask

  task automatic t_overlap();
    logic [31:0] v;
    for (int k = 0; k < 4; k++) wr(8'h10 + 8'(4*k), 32'h0000_0020);
    irq_src = 32'h0000_0020; settle();
    check("R6 all four lines", {28'd0, core_irq, core_mchk}, 32'hF);
    irq_src = 32'h0000_0000; settle();
    check("R7 all drop", {28'd0, core_irq, core_mchk}, 32'h0);
    rd(8'h00, v); check("R7 status cleared", v, 32'd0);
    irq_src = 32'hFFFE_0000; wr(8'h14, 32'hFFFF_FFFF); settle();
    check("R1 reserved pins cannot drive", {30'd0, core_irq}, 32'd0);
    irq_src = '0;
    for (int k = 0; k < 4; k++) wr(8'h10 + 8'(4*k), 32'd0);
  endtask

  task automatic t_high();
    logic [31:0] v;
    rd(8'h20, v); check("R8 none pending", v, 32'h8000_0000);
    wr(8'h10, 32'h0000_FFFF);
    irq_src = 32'h0001_0412; settle();
    rd(8'h20, v); check("R8 masked top ignored", v, 32'd10);
    wr(8'h10, 32'hFFFF_FFFF); settle();
    rd(8'h20, v); check("R8 top live bit", v, 32'd16);
    irq_src = 32'h8000_0001; settle();
    rd(8'h20, v); check("R8 reserved not counted", v, 32'd0);
    irq_src = '0; wr(8'h10, 32'd0); settle();
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    wr(8'h10, 32'h1234_5678);
    rd(8'h04, v); check("R9 offset 04", v, 32'd0);
    rd(8'h24, v); check("R9 offset 24", v, 32'd0);
    rd(8'h11, v); check("R9 offset 11", v, 32'd0);
    rd(8'hFC, v); check("R9 offset FC", v, 32'd0);
    @(negedge clk); bus_addr = 8'h10;
    @(negedge clk); bus_addr = 8'h04;
    #0.5;
    check("R10 data held until edge", bus_rdata, 32'h1234_5678);
    @(negedge clk);
    check("R10 data follows after edge", bus_rdata, 32'd0);
    wr(8'h10, 32'd0);
  endtask

  task automatic t_random();
    logic [31:0] m [4];
    logic [31:0] v, st;
    logic [3:0]  exp_o;
    for (int it = 0; it < 40; it++) begin
      for (int k = 0; k < 4; k++) begin
        rng = nxt(rng); m[k] = rng;
        wr(8'h10 + 8'(4*k), m[k]);
      end
      rng = nxt(rng); irq_src = rng & nxt(rng ^ 32'h55);
      settle();
      st = irq_src & LIVE;
      exp_o = {|(st & m[1]), |(st & m[0]), |(st & m[3]), |(st & m[2])};
      check("R5 random outputs", {28'd0, core_irq, core_mchk}, {28'd0, exp_o});
      rd(8'h00, v); check("R1 random status", v, st);
      rd(8'h20, v); check("R8 random highest", v, ref_high(st & m[0]));
    end
    irq_src = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask_rw();
    t_status();
    t_latency();
    t_overlap();
    t_high();
    t_unmapped();
    t_random();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule